// File: doc/BRIEF.md
# Branch Delay Slot Fetch Controller

This block steers instruction fetch in a five-stage in-order pipeline when a conditional branch is resolved in the decode stage. It owns the fetch program counter and the fetch/decode register. Each cycle it picks the next fetch address, and it can replace the word just fetched with a no-op. The decoder outside the block reports whether the decode stage holds a branch, whether that branch is taken, its target, and the direction bit encoded in the instruction. An upstream stall freezes the front end.

A static mode input picks how the one instruction fetched behind a branch is handled:
- **stall:** always discard that instruction and wait one cycle.
- **predict not taken:** discard it only when the branch is taken.
- **delayed branch:** it is a single delay slot that always executes.
- **cancelling branch:** the slot executes when the outcome matches the encoded prediction and is nullified otherwise.

A predict-taken code is accepted. It gives no gain here, because the target is known no earlier than the outcome, so it behaves exactly like predict not taken.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While reset is asserted, the fetch PC equals the reset address (default 0), the decode-stage valid flag is 0 and the decode-stage instruction is 0.
- R2: With no branch and no stall, the fetch PC advances by 4 every cycle. The decode register then captures the fetched word, its address and a set valid flag.
- R3: While the upstream stall is high, the fetch PC and the whole decode register hold their values, and a branch reported in that cycle causes no redirect and no squash.
- R4: In stall mode (mode code 0), every resolved branch turns the next decode-register entry into a bubble. A taken branch then fetches the target. A not-taken branch refetches the address after the branch. Either way, one cycle is lost.
- R5: In predict-not-taken mode (code 1), a taken branch squashes the instruction fetched behind it and fetch restarts at the target, losing one cycle.
- R6: In predict-not-taken mode, a not-taken branch loses no cycle, and the fall-through instruction enters decode valid.
- R7: Mode code 2 (predict taken) behaves identically to code 1 for both outcomes.
- R8: In delayed-branch mode (code 3), the single instruction after the branch always enters decode valid. The target is fetched right after it only when the branch is taken.
- R9: In cancelling mode (code 4), when the outcome equals the encoded prediction bit, the slot instruction enters decode valid and no cycle is lost.
- R10: In cancelling mode, when the outcome differs from the prediction, the slot instruction is nullified. Fetch then follows the actual outcome: the target when taken, or the instruction two after the branch when not taken.
- R11: A squash writes the all-zero no-op word into the decode register and clears its valid flag.
- R12: Mode codes 5 to 7 behave as stall mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Static branch policy code |
| upStall | input | 1 | Upstream stall, freezes PC and decode register |
| decBrValid | input | 1 | Decode stage holds a conditional branch |
| decBrTaken | input | 1 | Resolved branch outcome |
| decPredTaken | input | 1 | Prediction bit encoded in the branch |
| decBrTarget | input | 32 | Branch target address |
| fetchInstr | input | 32 | Word returned by instruction memory for fetchPc |
| fetchPc | output | 32 | Address being fetched this cycle |
| nextPc | output | 32 | Selected address for the next fetch |
| fetchHold | output | 1 | PC does not advance this cycle |
| squashSlot | output | 1 | Word fetched this cycle is replaced by a no-op |
| ifidInstr | output | 32 | Decode-stage instruction |
| ifidPc | output | 32 | Decode-stage instruction address |
| ifidValid | output | 1 | Decode-stage entry is valid |

## Verification
The bench places a branch at address 8 and runs it through every mode code, both outcomes and both prediction bits. It counts bubbles over the two cycles after resolution and checks the next valid decode entry.
- A design that squashed the delay slot on a taken delayed branch, or skipped the bubble on a not-taken stall-mode branch, would show the wrong bubble count.
- A design that nullified on a cancelling match, or kept the slot on a mismatch, would show a wrong valid flag.
- A design that advanced the PC after a not-taken stall-mode branch would skip the fall-through instruction.
- A design that let a branch act during an upstream stall would change the PC while it must be frozen.
- A design that kept the fetched word instead of zero on squash would show a wrong decode word.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [2:0] {
    MODE_STALL   = 3'd0,
    MODE_NOTAKEN = 3'd1,
    MODE_TAKEN   = 3'd2,
    MODE_DELAYED = 3'd3,
    MODE_CANCEL  = 3'd4
  } bfc_mode_e;

  // Strobes from the policy logic to the PC/decode-register datapath
  typedef struct packed {
    logic holdPc;    // keep current fetch PC
    logic redirect;  // load branch target
    logic squash;    // write no-op into decode register
    logic holdIfid;  // freeze decode register
  } bfc_strobe_t;
endpackage

// File: rtl/bfc_policy.sv
module bfc_policy
  import bfc_pkg::*;
(
  input  logic        [2:0] mode,
  input  logic              upStall,
  input  logic              decBrValid,
  input  logic              decBrTaken,
  input  logic              decPredTaken,
  output bfc_strobe_t       strobe
);
  logic resolve;
  logic mispredict;
  bfc_mode_e policy;

  assign resolve    = decBrValid & ~upStall;
  assign mispredict = decBrTaken ^ decPredTaken;
  assign policy     = bfc_mode_e'(mode);

  always_comb begin
    strobe          = '0;
    strobe.redirect = resolve & decBrTaken;
    unique case (policy)
      MODE_NOTAKEN, MODE_TAKEN: begin
        strobe.squash = resolve & decBrTaken;
      end
      MODE_DELAYED: begin
        strobe.squash = 1'b0;
      end
      MODE_CANCEL: begin
        strobe.squash = resolve & mispredict;
      end
      default: begin
        // stall policy and unused codes: always one bubble
        strobe.squash = resolve;
        strobe.holdPc = resolve & ~decBrTaken;
      end
    endcase
    if (upStall) begin
      strobe.holdPc   = 1'b1;
      strobe.holdIfid = 1'b1;
    end
  end
endmodule

// File: rtl/bfc_pcpath.sv
module bfc_pcpath
  import bfc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int IW          = 32,
  parameter int INSTR_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfc_strobe_t       strobe,
  input  logic [AW-1:0]     brTarget,
  input  logic [IW-1:0]     fetchInstr,
  output logic [AW-1:0]     fetchPc,
  output logic [AW-1:0]     nextPc,
  output logic [IW-1:0]     ifidInstr,
  output logic [AW-1:0]     ifidPc,
  output logic              ifidValid
);
  localparam logic [AW-1:0] PC_STEP = AW'(INSTR_BYTES);
  localparam logic [IW-1:0] NOP_WORD = '0;

  logic [AW-1:0] seqPc;
  assign seqPc = fetchPc + PC_STEP;

  always_comb begin
    if (strobe.redirect)    nextPc = brTarget;
    else if (strobe.holdPc) nextPc = fetchPc;
    else                    nextPc = seqPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fetchPc <= RESET_PC;
    else       fetchPc <= nextPc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifidInstr <= NOP_WORD;
      ifidPc    <= RESET_PC;
      ifidValid <= 1'b0;
    end else if (!strobe.holdIfid) begin
      ifidPc <= fetchPc;
      if (strobe.squash) begin
        ifidInstr <= NOP_WORD;
        ifidValid <= 1'b0;
      end else begin
        ifidInstr <= fetchInstr;
        ifidValid <= 1'b1;
      end
    end
  end

  // R11: a squash lands as the zero word with valid cleared
  p_squash_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.squash && !strobe.holdIfid) |=> (!ifidValid && ifidInstr == NOP_WORD));
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl
  import bfc_pkg::*;
#(
  parameter int AW          = 32,
  parameter int IW          = 32,
  parameter int INSTR_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    mode,
  input  logic          upStall,
  input  logic          decBrValid,
  input  logic          decBrTaken,
  input  logic          decPredTaken,
  input  logic [AW-1:0] decBrTarget,
  input  logic [IW-1:0] fetchInstr,
  output logic [AW-1:0] fetchPc,
  output logic [AW-1:0] nextPc,
  output logic          fetchHold,
  output logic          squashSlot,
  output logic [IW-1:0] ifidInstr,
  output logic [AW-1:0] ifidPc,
  output logic          ifidValid
);
  bfc_strobe_t strobe;

  bfc_policy u_policy (
    .mode         (mode),
    .upStall      (upStall),
    .decBrValid   (decBrValid),
    .decBrTaken   (decBrTaken),
    .decPredTaken (decPredTaken),
    .strobe       (strobe)
  );

  bfc_pcpath #(
    .AW(AW), .IW(IW), .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)
  ) u_pcpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .brTarget   (decBrTarget),
    .fetchInstr (fetchInstr),
    .fetchPc    (fetchPc),
    .nextPc     (nextPc),
    .ifidInstr  (ifidInstr),
    .ifidPc     (ifidPc),
    .ifidValid  (ifidValid)
  );

  assign fetchHold  = strobe.holdPc;
  assign squashSlot = strobe.squash;

  p_upstall_freeze_r3: assert property (@(posedge clk) disable iff (!rstN)
    upStall |=> (fetchPc == $past(fetchPc) && ifidPc == $past(ifidPc)
                 && ifidValid == $past(ifidValid)));

  p_stall_bubble_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decBrValid && !upStall && mode == 3'd0) |=> !ifidValid);

  p_pnt_redirect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decBrValid && !upStall && mode == 3'd1 && decBrTaken)
      |=> (fetchPc == $past(decBrTarget) && !ifidValid));

  p_delay_slot_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decBrValid && !upStall && mode == 3'd3) |=> ifidValid);

  p_cancel_nullify_r10: assert property (@(posedge clk) disable iff (!rstN)
    (decBrValid && !upStall && mode == 3'd4 && (decBrTaken != decPredTaken))
      |=> !ifidValid);
endmodule

// File: tb/sim_branch_fetch_ctrl.sv
module sim_branch_fetch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BR_PC  = 32'h8;
  localparam logic [31:0] TGT_PC = 32'h100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        upStall = 1'b0;
  logic        decBrValid = 1'b0;
  logic        decBrTaken = 1'b0;
  logic        decPredTaken = 1'b0;
  logic [31:0] decBrTarget = TGT_PC;
  logic [31:0] fetchInstr;
  logic [31:0] fetchPc, nextPc, ifidInstr, ifidPc;
  logic        fetchHold, squashSlot, ifidValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {16'hC0DE, a[15:0]};
  endfunction
  assign fetchInstr = memWord(fetchPc);

  branch_fetch_ctrl u0 (
    .clk(clk), .rstN(rstN), .mode(mode), .upStall(upStall),
    .decBrValid(decBrValid), .decBrTaken(decBrTaken),
    .decPredTaken(decPredTaken), .decBrTarget(decBrTarget),
    .fetchInstr(fetchInstr), .fetchPc(fetchPc), .nextPc(nextPc),
    .fetchHold(fetchHold), .squashSlot(squashSlot),
    .ifidInstr(ifidInstr), .ifidPc(ifidPc), .ifidValid(ifidValid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic resetDut(input logic [2:0] m);
    @(negedge clk);
    rstN = 1'b0; mode = m; upStall = 1'b0; decBrValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // wait until the branch address sits valid in decode
  task automatic waitBranch();
    for (int i = 0; i < 8; i++) begin
      if (ifidValid && ifidPc == BR_PC) break;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 pc", fetchPc, 32'h0);
    chk("R1 valid", {31'b0, ifidValid}, 32'h0);
    chk("R1 instr", ifidInstr, 32'h0);
  endtask

  task automatic testSequential();
    resetDut(3'd1);
    for (int i = 0; i < 3; i++) begin
      chk("R2 pc", fetchPc, 32'(i * 4));
      @(negedge clk);
      chk("R2 valid", {31'b0, ifidValid}, 32'h1);
      chk("R2 ifidPc", ifidPc, 32'(i * 4));
      chk("R2 instr", ifidInstr, memWord(32'(i * 4)));
    end
  endtask

  task automatic runBranch(input logic [2:0] m, input bit tk, input bit pr,
                           input bit expSq, input logic [31:0] expPc,
                           input string rq);
    int bub = 0;
    resetDut(m);
    waitBranch();
    chk({rq, " slot addr"}, fetchPc, BR_PC + 32'd4);
    decBrValid = 1'b1; decBrTaken = tk; decPredTaken = pr;
    #1;
    chk({rq, " squash strobe"}, {31'b0, squashSlot}, {31'b0, expSq});
    @(negedge clk);
    decBrValid = 1'b0;
    if (!ifidValid) bub++;
    chk({rq, " slot valid"}, {31'b0, ifidValid}, {31'b0, ~expSq});
    if (expSq) chk({rq, " R11 nop word"}, ifidInstr, 32'h0);
    chk({rq, " next fetch"}, fetchPc, expPc);
    @(negedge clk);
    if (!ifidValid) bub++;
    chk({rq, " following entry"}, ifidPc, expPc);
    chk({rq, " bubbles"}, 32'(bub), {31'b0, expSq});
  endtask

  task automatic testUpStall();
    resetDut(3'd1);
    waitBranch();
    upStall = 1'b1;
    decBrValid = 1'b1; decBrTaken = 1'b1; decPredTaken = 1'b0;
    @(negedge clk);
    chk("R3 pc frozen", fetchPc, BR_PC + 32'd4);
    chk("R3 ifid frozen", ifidPc, BR_PC);
    chk("R3 no squash", {31'b0, ifidValid}, 32'h1);
    @(negedge clk);
    chk("R3 still frozen", fetchPc, BR_PC + 32'd4);
    upStall = 1'b0;
    @(negedge clk);
    decBrValid = 1'b0;
    chk("R3 resolves after stall", fetchPc, TGT_PC);
    chk("R3 squash after stall", {31'b0, ifidValid}, 32'h0);
  endtask

  initial begin
    testReset();
    testSequential();
    testUpStall();
    runBranch(3'd0, 1'b1, 1'b0, 1'b1, TGT_PC,     "R4 taken");
    runBranch(3'd0, 1'b0, 1'b0, 1'b1, 32'hC,      "R4 not-taken");
    runBranch(3'd1, 1'b1, 1'b0, 1'b1, TGT_PC,     "R5");
    runBranch(3'd1, 1'b0, 1'b0, 1'b0, 32'h10,     "R6");
    runBranch(3'd2, 1'b1, 1'b1, 1'b1, TGT_PC,     "R7 taken");
    runBranch(3'd2, 1'b0, 1'b1, 1'b0, 32'h10,     "R7 not-taken");
    runBranch(3'd3, 1'b1, 1'b0, 1'b0, TGT_PC,     "R8 taken");
    runBranch(3'd3, 1'b0, 1'b0, 1'b0, 32'h10,     "R8 not-taken");
    runBranch(3'd4, 1'b1, 1'b1, 1'b0, TGT_PC,     "R9 taken");
    runBranch(3'd4, 1'b0, 1'b0, 1'b0, 32'h10,     "R9 not-taken");
    runBranch(3'd4, 1'b0, 1'b1, 1'b1, 32'h10,     "R10 pred-taken");
    runBranch(3'd4, 1'b1, 1'b0, 1'b1, TGT_PC,     "R10 pred-not-taken");
    runBranch(3'd5, 1'b1, 1'b0, 1'b1, TGT_PC,     "R12 code5");
    runBranch(3'd7, 1'b0, 1'b0, 1'b1, 32'hC,      "R12 code7");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule